// File: doc/BRIEF.md
# Selective Load Value Predictor

This block supplies a speculative result for load instructions that miss in the level-one data cache, so that the instructions that consume the load can execute before the miss is serviced. It keeps one table per hardware thread. Each table is addressed by the load's program counter and keeps, per entry, a tag, the last value that load returned and a two-bit confidence counter. A prediction is handed out only for a missing load whose entry has a matching tag and enough confidence. Loads that hit in the cache never use the table.

When the real data returns, the pipeline presents the load on the verify port. The block compares the real data with the stored value and trains the entry. If the load had been predicted and the guess is wrong, it raises a one-cycle recovery pulse that carries the load's reorder-buffer tag. The pipeline uses that pulse to squash and reissue only the dependants of the load. The squash logic and the cache itself lie outside this block.

Top module: `sel_load_predictor`

## Requirements
- R1: After reset every table entry is invalid, `lu_pred_valid` and `rc_pulse` are low, and a lookup for any PC returns no prediction.
- R2: A prediction is returned only when `lu_req` and `lu_l1_miss` are both high. A request with `lu_l1_miss` low, or a cycle without `lu_req`, returns `lu_pred_valid` low.
- R3: The entry index is PC bits [PC_LSB+IDX_W-1:PC_LSB], that is [11:2] with the defaults, and the tag is every PC bit above them. Two PCs that share an index but differ in tag never predict for each other. Verifying one of them evicts the other.
- R4: A prediction is returned only when the stored tag matches and the confidence is at least 2. A newly allocated entry starts at confidence 0, and each correct verification adds one.
- R5: Confidence saturates at 3. Further correct verifications keep the entry predicting.
- R6: A verification whose value differs from the stored value of a matching entry clears the confidence to 0 and stores the new value. A verification with no matching tag allocates the entry with the actual value and confidence 0.
- R7: `rc_pulse` is high for one cycle, in the cycle after a verification with `vf_was_pred` high whose value differs from the stored value or whose entry no longer matches. `rc_rob_tag` then carries that verification's `vf_rob_tag`. No pulse follows a verification with `vf_was_pred` low or a correct value.
- R8: Each hardware thread has its own table. Training under one thread index never produces a prediction for another thread.
- R9: The response appears in the cycle after the request, with `lu_pred_value` equal to the last stored value. `lu_pred_value` is zero whenever `lu_pred_valid` is low.
- R10: A lookup and a verification of the same entry in the same cycle: the lookup sees the table as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_req | input | 1 | Lookup request for a load |
| lu_thread | input | THR_W | Hardware thread of the lookup |
| lu_pc | input | PC_W | PC of the load being looked up |
| lu_l1_miss | input | 1 | Load missed in the L1 data cache |
| lu_pred_valid | output | 1 | A prediction is supplied (one cycle after request) |
| lu_pred_value | output | VAL_W | Predicted load value, zero when not valid |
| vf_valid | input | 1 | Verification of a missing load |
| vf_thread | input | THR_W | Hardware thread of the verification |
| vf_pc | input | PC_W | PC of the verified load |
| vf_value | input | VAL_W | Actual value returned by memory |
| vf_was_pred | input | 1 | The load had consumed a prediction |
| vf_rob_tag | input | ROB_W | Reorder-buffer tag of the verified load |
| rc_pulse | output | 1 | One-cycle selective reissue request |
| rc_rob_tag | output | ROB_W | Tag of the load whose dependants must reissue |

## Verification
A lookup and a verification can address the same entry in the same clock cycle. The lookup must then see the entry as it stood before the update. The bench provokes this by training an entry to full confidence and then, in one cycle, driving a lookup of that PC together with a wrong-valued, predicted verification. In the following cycle it expects both the old value on the prediction output and the recovery pulse with the verification's tag. A further lookup must then return nothing, because the confidence was reset.

// File: rtl/slvp_pkg.sv
package slvp_pkg;

   typedef enum logic [1:0] {
      VF_ALLOC   = 2'd0,
      VF_CONFIRM = 2'd1,
      VF_REPLACE = 2'd2
   } vf_outcome_e;

   function automatic int unsigned thr_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lvp_index_split.sv
module lvp_index_split #(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned PC_LSB = 2,
   localparam int unsigned TAG_W = PC_W - IDX_W - PC_LSB
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);

   assign idx = pc[PC_LSB +: IDX_W];
   assign tag = pc[PC_W-1 -: TAG_W];

   generate
      if (PC_LSB > 0) begin : g_lsb
         logic unused_lsb;
         assign unused_lsb = ^pc[PC_LSB-1:0];
      end
   endgenerate

endmodule

// File: rtl/lvp_table.sv
module lvp_table #(
   parameter int unsigned ENTRIES = 1024,
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned VAL_W   = 32,
   parameter int unsigned CONF_W  = 2,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic              ra_vld,
   output logic [TAG_W-1:0]  ra_tag,
   output logic [VAL_W-1:0]  ra_val,
   output logic [CONF_W-1:0] ra_conf,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic              rb_vld,
   output logic [TAG_W-1:0]  rb_tag,
   output logic [VAL_W-1:0]  rb_val,
   output logic [CONF_W-1:0] rb_conf,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [TAG_W-1:0]  w_tag,
   input  logic [VAL_W-1:0]  w_val,
   input  logic [CONF_W-1:0] w_conf
);

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_mem  [ENTRIES];
   logic [VAL_W-1:0]   val_mem  [ENTRIES];
   logic [CONF_W-1:0]  conf_mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (we) begin
         vld_q[w_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         tag_mem[w_idx]  <= w_tag;
         val_mem[w_idx]  <= w_val;
         conf_mem[w_idx] <= w_conf;
      end
   end

   assign ra_vld  = vld_q[ra_idx];
   assign ra_tag  = tag_mem[ra_idx];
   assign ra_val  = val_mem[ra_idx];
   assign ra_conf = conf_mem[ra_idx];

   assign rb_vld  = vld_q[rb_idx];
   assign rb_tag  = tag_mem[rb_idx];
   assign rb_val  = val_mem[rb_idx];
   assign rb_conf = conf_mem[rb_idx];

endmodule

// File: rtl/lvp_train.sv
module lvp_train
   import slvp_pkg::*;
#(
   parameter int unsigned VAL_W  = 32,
   parameter int unsigned CONF_W = 2
) (
   input  logic              hit,
   input  logic [VAL_W-1:0]  stored_val,
   input  logic [CONF_W-1:0] stored_conf,
   input  logic [VAL_W-1:0]  actual_val,
   input  logic              was_pred,
   output logic [VAL_W-1:0]  next_val,
   output logic [CONF_W-1:0] next_conf,
   output logic              wrong,
   output vf_outcome_e       outcome
);

   always_comb begin
      if (!hit) begin
         outcome = VF_ALLOC;
      end else if (stored_val == actual_val) begin
         outcome = VF_CONFIRM;
      end else begin
         outcome = VF_REPLACE;
      end
   end

   always_comb begin
      next_val  = actual_val;
      next_conf = '0;
      unique case (outcome)
         VF_CONFIRM: begin
            next_val  = stored_val;
            next_conf = (stored_conf == '1) ? stored_conf : stored_conf + 1'b1;
         end
         default: begin
            next_val  = actual_val;
            next_conf = '0;
         end
      endcase
   end

   assign wrong = was_pred && (outcome != VF_CONFIRM);

endmodule

// File: rtl/sel_load_predictor.sv
module sel_load_predictor
   import slvp_pkg::*;
#(
   parameter int unsigned THREADS     = 2,
   parameter int unsigned ENTRIES     = 1024,
   parameter int unsigned PC_W        = 32,
   parameter int unsigned PC_LSB      = 2,
   parameter int unsigned VAL_W       = 32,
   parameter int unsigned ROB_W       = 6,
   parameter int unsigned CONF_W      = 2,
   parameter int unsigned CONF_THRESH = 2,
   localparam int unsigned THR_W      = thr_width(THREADS),
   localparam int unsigned IDX_W      = $clog2(ENTRIES),
   localparam int unsigned TAG_W      = PC_W - IDX_W - PC_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lu_req,
   input  logic [THR_W-1:0] lu_thread,
   input  logic [PC_W-1:0]  lu_pc,
   input  logic             lu_l1_miss,
   output logic             lu_pred_valid,
   output logic [VAL_W-1:0] lu_pred_value,
   input  logic             vf_valid,
   input  logic [THR_W-1:0] vf_thread,
   input  logic [PC_W-1:0]  vf_pc,
   input  logic [VAL_W-1:0] vf_value,
   input  logic             vf_was_pred,
   input  logic [ROB_W-1:0] vf_rob_tag,
   output logic             rc_pulse,
   output logic [ROB_W-1:0] rc_rob_tag
);

   generate
      if ((1 << IDX_W) != ENTRIES) begin : g_bad_entries
         $error("ENTRIES must be a power of two");
      end
      if (THREADS < 1) begin : g_bad_threads
         $error("THREADS must be at least one");
      end
      if (CONF_THRESH >= (1 << CONF_W)) begin : g_bad_thresh
         $error("CONF_THRESH must fit in CONF_W bits");
      end
      if (PC_W <= IDX_W + PC_LSB) begin : g_bad_pc
         $error("PC_W leaves no tag bits");
      end
   endgenerate

   logic [IDX_W-1:0] lu_idx, vf_idx;
   logic [TAG_W-1:0] lu_tag, vf_tag;

   lvp_index_split #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_lu_split (
      .pc(lu_pc), .idx(lu_idx), .tag(lu_tag)
   );

   lvp_index_split #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_vf_split (
      .pc(vf_pc), .idx(vf_idx), .tag(vf_tag)
   );

   logic              t_lu_vld  [THREADS];
   logic [TAG_W-1:0]  t_lu_tag  [THREADS];
   logic [VAL_W-1:0]  t_lu_val  [THREADS];
   logic [CONF_W-1:0] t_lu_conf [THREADS];
   logic              t_vf_vld  [THREADS];
   logic [TAG_W-1:0]  t_vf_tag  [THREADS];
   logic [VAL_W-1:0]  t_vf_val  [THREADS];
   logic [CONF_W-1:0] t_vf_conf [THREADS];

   logic [VAL_W-1:0]  wr_val;
   logic [CONF_W-1:0] wr_conf;

   genvar t;
   generate
      for (t = 0; t < THREADS; t++) begin : g_thr
         logic we_t;
         assign we_t = vf_valid && (vf_thread == THR_W'(t));

         lvp_table #(
            .ENTRIES(ENTRIES), .TAG_W(TAG_W), .VAL_W(VAL_W), .CONF_W(CONF_W)
         ) u_tbl (
            .clk(clk), .rst_n(rst_n),
            .ra_idx(lu_idx), .ra_vld(t_lu_vld[t]), .ra_tag(t_lu_tag[t]),
            .ra_val(t_lu_val[t]), .ra_conf(t_lu_conf[t]),
            .rb_idx(vf_idx), .rb_vld(t_vf_vld[t]), .rb_tag(t_vf_tag[t]),
            .rb_val(t_vf_val[t]), .rb_conf(t_vf_conf[t]),
            .we(we_t), .w_idx(vf_idx), .w_tag(vf_tag),
            .w_val(wr_val), .w_conf(wr_conf)
         );
      end
   endgenerate

   logic              lu_sel_vld, vf_sel_vld;
   logic [TAG_W-1:0]  lu_sel_tag, vf_sel_tag;
   logic [VAL_W-1:0]  lu_sel_val, vf_sel_val;
   logic [CONF_W-1:0] lu_sel_conf, vf_sel_conf;

   always_comb begin
      lu_sel_vld  = 1'b0;
      lu_sel_tag  = '0;
      lu_sel_val  = '0;
      lu_sel_conf = '0;
      vf_sel_vld  = 1'b0;
      vf_sel_tag  = '0;
      vf_sel_val  = '0;
      vf_sel_conf = '0;
      for (int i = 0; i < THREADS; i++) begin
         if (lu_thread == THR_W'(i)) begin
            lu_sel_vld  = t_lu_vld[i];
            lu_sel_tag  = t_lu_tag[i];
            lu_sel_val  = t_lu_val[i];
            lu_sel_conf = t_lu_conf[i];
         end
         if (vf_thread == THR_W'(i)) begin
            vf_sel_vld  = t_vf_vld[i];
            vf_sel_tag  = t_vf_tag[i];
            vf_sel_val  = t_vf_val[i];
            vf_sel_conf = t_vf_conf[i];
         end
      end
   end

   logic lu_hit;
   assign lu_hit = lu_req && lu_l1_miss && lu_sel_vld && (lu_sel_tag == lu_tag)
                   && (lu_sel_conf >= CONF_W'(CONF_THRESH));

   logic        vf_hit, vf_wrong;
   vf_outcome_e vf_outcome;
   assign vf_hit = vf_sel_vld && (vf_sel_tag == vf_tag);

   lvp_train #(.VAL_W(VAL_W), .CONF_W(CONF_W)) u_train (
      .hit(vf_hit), .stored_val(vf_sel_val), .stored_conf(vf_sel_conf),
      .actual_val(vf_value), .was_pred(vf_was_pred),
      .next_val(wr_val), .next_conf(wr_conf),
      .wrong(vf_wrong), .outcome(vf_outcome)
   );

   logic unused_outcome;
   assign unused_outcome = ^vf_outcome;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lu_pred_valid <= 1'b0;
         lu_pred_value <= '0;
         rc_pulse      <= 1'b0;
         rc_rob_tag    <= '0;
      end else begin
         lu_pred_valid <= lu_hit;
         lu_pred_value <= lu_hit ? lu_sel_val : '0;
         rc_pulse      <= vf_valid && vf_wrong;
         rc_rob_tag    <= (vf_valid && vf_wrong) ? vf_rob_tag : '0;
      end
   end

endmodule

// File: rtl/sel_load_predictor_chk.sv
module sel_load_predictor_chk #(
   parameter int unsigned THR_W = 1,
   parameter int unsigned PC_W  = 32,
   parameter int unsigned VAL_W = 32,
   parameter int unsigned ROB_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lu_req,
   input logic             lu_l1_miss,
   input logic             lu_pred_valid,
   input logic [VAL_W-1:0] lu_pred_value,
   input logic             vf_valid,
   input logic             vf_was_pred,
   input logic [ROB_W-1:0] vf_rob_tag,
   input logic             rc_pulse,
   input logic [ROB_W-1:0] rc_rob_tag
);

   assert_hit_no_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(lu_req && lu_l1_miss) |=> !lu_pred_valid);

   assert_zero_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lu_pred_valid |-> (lu_pred_value == '0));

   assert_no_pulse_unpred_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(vf_valid && vf_was_pred) |=> !rc_pulse);

   assert_pulse_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vf_valid && vf_was_pred) |=> (!rc_pulse || (rc_rob_tag == $past(vf_rob_tag))));

   assert_tag_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rc_pulse |-> (rc_rob_tag == '0));

endmodule

bind sel_load_predictor sel_load_predictor_chk #(
   .THR_W(THR_W), .PC_W(PC_W), .VAL_W(VAL_W), .ROB_W(ROB_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lu_req(lu_req), .lu_l1_miss(lu_l1_miss),
   .lu_pred_valid(lu_pred_valid), .lu_pred_value(lu_pred_value),
   .vf_valid(vf_valid), .vf_was_pred(vf_was_pred), .vf_rob_tag(vf_rob_tag),
   .rc_pulse(rc_pulse), .rc_rob_tag(rc_rob_tag)
);

// File: tb/sel_load_predictor_tb_top.sv
`timescale 1ns/1ps
module sel_load_predictor_tb_top;

   localparam int unsigned ENTRIES = 1024;
   localparam int unsigned PC_W    = 32;
   localparam int unsigned VAL_W   = 32;
   localparam int unsigned ROB_W   = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lu_req = 1'b0;
   logic [0:0]       lu_thread = '0;
   logic [PC_W-1:0]  lu_pc = '0;
   logic             lu_l1_miss = 1'b0;
   logic             lu_pred_valid;
   logic [VAL_W-1:0] lu_pred_value;
   logic             vf_valid = 1'b0;
   logic [0:0]       vf_thread = '0;
   logic [PC_W-1:0]  vf_pc = '0;
   logic [VAL_W-1:0] vf_value = '0;
   logic             vf_was_pred = 1'b0;
   logic [ROB_W-1:0] vf_rob_tag = '0;
   logic             rc_pulse;
   logic [ROB_W-1:0] rc_rob_tag;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sel_load_predictor dut_i (
      .clk(clk), .rst_n(rst_n),
      .lu_req(lu_req), .lu_thread(lu_thread), .lu_pc(lu_pc), .lu_l1_miss(lu_l1_miss),
      .lu_pred_valid(lu_pred_valid), .lu_pred_value(lu_pred_value),
      .vf_valid(vf_valid), .vf_thread(vf_thread), .vf_pc(vf_pc), .vf_value(vf_value),
      .vf_was_pred(vf_was_pred), .vf_rob_tag(vf_rob_tag),
      .rc_pulse(rc_pulse), .rc_rob_tag(rc_rob_tag)
   );

   localparam logic [PC_W-1:0] PC_A = 32'h0000_1040;
   localparam logic [PC_W-1:0] PC_B = PC_A + (ENTRIES << 2);
   localparam logic [PC_W-1:0] PC_C = 32'h0000_3208;
   localparam logic [PC_W-1:0] PC_D = 32'h0000_7F00;
   localparam logic [PC_W-1:0] PC_E = 32'h0000_5A14;

   task automatic check(input string req, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic step(input logic lr, input logic lt, input logic [PC_W-1:0] lpc,
                       input logic lm, input logic vv, input logic vt,
                       input logic [PC_W-1:0] vpc, input logic [VAL_W-1:0] vval,
                       input logic vwp, input logic [ROB_W-1:0] vtag);
      @(negedge clk);
      lu_req = lr; lu_thread = lt; lu_pc = lpc; lu_l1_miss = lm;
      vf_valid = vv; vf_thread = vt; vf_pc = vpc; vf_value = vval;
      vf_was_pred = vwp; vf_rob_tag = vtag;
      @(negedge clk);
      lu_req = 1'b0; lu_l1_miss = 1'b0; vf_valid = 1'b0; vf_was_pred = 1'b0;
      vf_rob_tag = '0;
   endtask

   task automatic lookup(input logic th, input logic [PC_W-1:0] pc, input logic miss);
      step(1'b1, th, pc, miss, 1'b0, 1'b0, '0, '0, 1'b0, '0);
   endtask

   task automatic verify(input logic th, input logic [PC_W-1:0] pc,
                         input logic [VAL_W-1:0] v, input logic wp,
                         input logic [ROB_W-1:0] tg);
      step(1'b0, 1'b0, '0, 1'b0, 1'b1, th, pc, v, wp, tg);
   endtask

   task automatic expect_pred(input string req, input logic valid,
                              input logic [VAL_W-1:0] v);
      check(req, "pred_valid", 64'(lu_pred_valid), 64'(valid));
      check(req, "pred_value", 64'(lu_pred_value), 64'(valid ? v : '0));
   endtask

   task automatic t_reset;
      check("R1", "pred_valid after reset", 64'(lu_pred_valid), 64'd0);
      check("R1", "rc_pulse after reset", 64'(rc_pulse), 64'd0);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R1", 1'b0, '0);
   endtask

   task automatic t_threshold;
      verify(1'b0, PC_A, 32'hCAFE_0001, 1'b0, 6'd1);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R4 conf0", 1'b0, '0);
      verify(1'b0, PC_A, 32'hCAFE_0001, 1'b0, 6'd2);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R4 conf1", 1'b0, '0);
      verify(1'b0, PC_A, 32'hCAFE_0001, 1'b0, 6'd3);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R4 R9 conf2", 1'b1, 32'hCAFE_0001);
   endtask

   task automatic t_hit_ignored;
      lookup(1'b0, PC_A, 1'b0);
      expect_pred("R2 l1 hit", 1'b0, '0);
      step(1'b0, 1'b0, PC_A, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0);
      expect_pred("R2 no req", 1'b0, '0);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R2 entry intact", 1'b1, 32'hCAFE_0001);
   endtask

   task automatic t_saturate;
      verify(1'b0, PC_A, 32'hCAFE_0001, 1'b1, 6'd4);
      check("R7", "no pulse on correct", 64'(rc_pulse), 64'd0);
      verify(1'b0, PC_A, 32'hCAFE_0001, 1'b1, 6'd5);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R5 saturated", 1'b1, 32'hCAFE_0001);
   endtask

   task automatic t_wrong;
      verify(1'b0, PC_A, 32'hBEEF_0002, 1'b1, 6'h15);
      check("R7", "pulse on wrong", 64'(rc_pulse), 64'd1);
      check("R7", "pulse tag", 64'(rc_rob_tag), 64'h15);
      @(negedge clk);
      check("R7", "pulse one cycle", 64'(rc_pulse), 64'd0);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R6 conf cleared", 1'b0, '0);
      verify(1'b0, PC_A, 32'hBEEF_0002, 1'b0, 6'd6);
      verify(1'b0, PC_A, 32'hBEEF_0002, 1'b0, 6'd7);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R6 value replaced", 1'b1, 32'hBEEF_0002);
   endtask

   task automatic t_no_pulse;
      verify(1'b0, PC_E, 32'h1111_1111, 1'b0, 6'd8);
      verify(1'b0, PC_E, 32'h2222_2222, 1'b0, 6'd9);
      check("R7", "no pulse unpredicted wrong", 64'(rc_pulse), 64'd0);
      verify(1'b0, PC_D, 32'h3333_3333, 1'b1, 6'h2A);
      check("R7", "pulse on evicted predicted", 64'(rc_pulse), 64'd1);
      check("R7", "evicted pulse tag", 64'(rc_rob_tag), 64'h2A);
   endtask

   task automatic t_alias;
      lookup(1'b0, PC_B, 1'b1);
      expect_pred("R3 alias no pred", 1'b0, '0);
      verify(1'b0, PC_B, 32'h4444_4444, 1'b0, 6'd10);
      lookup(1'b0, PC_A, 1'b1);
      expect_pred("R3 evicted", 1'b0, '0);
      verify(1'b0, PC_B, 32'h4444_4444, 1'b0, 6'd11);
      verify(1'b0, PC_B, 32'h4444_4444, 1'b0, 6'd12);
      lookup(1'b0, PC_B, 1'b1);
      expect_pred("R3 new owner", 1'b1, 32'h4444_4444);
   endtask

   task automatic t_thread;
      for (int k = 0; k < 3; k++) verify(1'b0, PC_C, 32'h5555_AAAA, 1'b0, 6'd13);
      lookup(1'b1, PC_C, 1'b1);
      expect_pred("R8 other thread", 1'b0, '0);
      lookup(1'b0, PC_C, 1'b1);
      expect_pred("R8 own thread", 1'b1, 32'h5555_AAAA);
   endtask

   task automatic t_same_cycle;
      step(1'b1, 1'b0, PC_C, 1'b1, 1'b1, 1'b0, PC_C, 32'h6666_0000, 1'b1, 6'h33);
      expect_pred("R10 old value", 1'b1, 32'h5555_AAAA);
      check("R10", "pulse", 64'(rc_pulse), 64'd1);
      check("R10", "pulse tag", 64'(rc_rob_tag), 64'h33);
      lookup(1'b0, PC_C, 1'b1);
      expect_pred("R10 after update", 1'b0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_threshold();
      t_hit_ignored();
      t_saturate();
      t_wrong();
      t_no_pulse();
      t_alias();
      t_thread();
      t_same_cycle();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule